// File: doc/BRIEF.md
# Integer Minimum/Maximum Unit

This block picks the smaller or the larger of two integer operands of width XLEN and returns the chosen operand unchanged. A 3-bit mode input sets three things. It chooses whether the whole word or only its lower half takes part in the ordering. It chooses whether that ordering is signed or unsigned. It chooses whether the minimum or the maximum is returned. Every mode runs through a single unsigned less-than comparator. The operands are shaped before they reach it. In half-width mode the lower half is moved to the top and zero-filled below. In signed mode the top bit is inverted. In max mode the two shaped operands trade places.

The output is always the full original operand that wins, even when only the lower halves were compared. If the first operand wins and its register index is zero, the output is zero instead of the operand. When condition recording is on, the unit also produces a 4-bit condition field. That field gives the ordering of the first operand against the second under the chosen width and sign rules, plus a copy of the summary-overflow input. Both outputs are registered and appear one clock after the inputs are presented.

Top module: `minmax_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `result` and `cr` are cleared to zero on that edge.
- R2: With mode 3'b000, `result` is the unsigned minimum of `a` and `b`, one clock after the inputs.
- R3: Mode bit 1 set makes the ordering signed (two's complement) and otherwise leaves the selection rule unchanged.
- R4: Mode bit 0 set orders the operands by their lower XLEN/2 bits only. `result` is still the complete XLEN-bit winning operand.
- R5: Mode bit 2 set returns the maximum instead of the minimum.
- R6: When the operands are equal under the chosen width and sign rule, `result` is taken from `a`, in both min and max modes.
- R7: When `a` is chosen and `ra_is_zero` is high, `result` is zero. When `b` is chosen, `ra_is_zero` has no effect.
- R8: With `rc` high, `cr` is {less, greater, equal, `so_in`}. Bit 3 means a<b, bit 2 means a>b and bit 1 means a==b, all under the chosen width and sign rule. The field does not depend on mode bit 2. Exactly one of bits 3..1 is set.
- R9: With `rc` low, `cr` is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a | input | XLEN | First operand |
| b | input | XLEN | Second operand |
| ra_is_zero | input | 1 | First operand's register index is zero; substitute zero when it is chosen |
| mode | input | 3 | bit0 half-width, bit1 signed, bit2 max |
| rc | input | 1 | Enable the condition field |
| so_in | input | 1 | Summary-overflow bit copied into cr[0] |
| result | output | XLEN | Chosen operand, registered |
| cr | output | 4 | Condition field, registered |

## Verification
Each operand pair yields both outputs exactly one rising edge later, since both leave the same register stage. The driver changes the inputs on the falling edge and records the expected pair in a queue. The monitor reads the outputs just after the next rising edge, when the pair for that item has been captured, so each queued item lines up with the one edge that registers it. The reset value is read in the same way, after an edge taken with reset high.

// File: rtl/minmax_pkg.sv
package minmax_pkg;

  // Mode encoding; packed order gives bit2 = max, bit1 = signed, bit0 = half
  typedef struct packed {
    logic pick_max;
    logic signed_ord;
    logic half_width;
  } mm_mode_t;

  // Ordering flags of the first operand against the second
  typedef struct packed {
    logic less;
    logic greater;
    logic equal;
  } mm_order_t;

  function automatic logic [3:0] pack_cond(input mm_order_t ord, input logic so);
    return {ord.less, ord.greater, ord.equal, so};
  endfunction

endpackage

// File: rtl/mm_precond.sv
module mm_precond #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] src,
  input  logic            half_width,
  input  logic            signed_ord,
  output logic [XLEN-1:0] shaped
);
  localparam int HALF = XLEN / 2;

  always_comb begin
    if (half_width) begin
      shaped = {src[HALF-1:0], {(XLEN - HALF){1'b0}}};
    end else begin
      shaped = src;
    end
    // moving the sign bit to the unsigned top of the range
    shaped[XLEN-1] = shaped[XLEN-1] ^ signed_ord;
  end
endmodule

// File: rtl/mm_ult.sv
module mm_ult #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] lhs,
  input  logic [XLEN-1:0] rhs,
  output logic            below,
  output logic            same
);
  always_comb begin
    below = (lhs < rhs);
    same  = (lhs == rhs);
  end
endmodule

// File: rtl/mm_pick.sv
module mm_pick #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]        a,
  input  logic [XLEN-1:0]        b,
  input  logic                   ra_is_zero,
  input  logic                   pick_max,
  input  logic                   below,
  input  logic                   same,
  output logic [XLEN-1:0]        chosen,
  output minmax_pkg::mm_order_t  order
);
  logic take_b;
  logic differ;

  always_comb begin
    // below compares (b,a) in min mode and (a,b) in max mode
    take_b = below;
    differ = ~same;
    if (take_b) begin
      chosen = b;
    end else if (ra_is_zero) begin
      chosen = '0;
    end else begin
      chosen = a;
    end
    order.equal   = same;
    order.less    = pick_max ? below : (differ & ~below);
    order.greater = pick_max ? (differ & ~below) : below;
  end
endmodule

// File: rtl/minmax_unit.sv
module minmax_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            ra_is_zero,
  input  logic [2:0]      mode,
  input  logic            rc,
  input  logic            so_in,
  output logic [XLEN-1:0] result,
  output logic [3:0]      cr
);
  import minmax_pkg::*;

  mm_mode_t        md;
  logic [XLEN-1:0] ca, cb;
  logic [XLEN-1:0] cmp_l, cmp_r;
  logic            below, same;
  logic [XLEN-1:0] chosen;
  mm_order_t       order;

  assign md = mm_mode_t'(mode);

  mm_precond #(.XLEN(XLEN)) u_pre_a (
    .src(a), .half_width(md.half_width), .signed_ord(md.signed_ord), .shaped(ca)
  );
  mm_precond #(.XLEN(XLEN)) u_pre_b (
    .src(b), .half_width(md.half_width), .signed_ord(md.signed_ord), .shaped(cb)
  );

  // min asks "b below a", max swaps to ask "a below b"; ties keep a
  always_comb begin
    if (md.pick_max) begin
      cmp_l = ca;
      cmp_r = cb;
    end else begin
      cmp_l = cb;
      cmp_r = ca;
    end
  end

  mm_ult #(.XLEN(XLEN)) u_cmp (
    .lhs(cmp_l), .rhs(cmp_r), .below(below), .same(same)
  );

  mm_pick #(.XLEN(XLEN)) u_pick (
    .a(a), .b(b), .ra_is_zero(ra_is_zero), .pick_max(md.pick_max),
    .below(below), .same(same), .chosen(chosen), .order(order)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      cr     <= '0;
    end else begin
      result <= chosen;
      cr     <= rc ? pack_cond(order, so_in) : 4'b0000;
    end
  end
endmodule

// File: rtl/minmax_unit_checker.sv
module minmax_unit_checker #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] a,
  input logic [XLEN-1:0] b,
  input logic            ra_is_zero,
  input logic [2:0]      mode,
  input logic            rc,
  input logic            so_in,
  input logic [XLEN-1:0] result,
  input logic [3:0]      cr
);
  localparam int HALF = XLEN / 2;

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (result == '0 && cr == 4'b0000));

  assert_operand_only_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (result == $past(a) || result == $past(b) || result == '0));

  assert_half_tie_keeps_a_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode[0]) && !$past(ra_is_zero) &&
     $past(a[HALF-1:0]) == $past(b[HALF-1:0])) |-> result == $past(a));

  assert_zero_subst_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ra_is_zero) && result != $past(b)) |-> result == '0);

  assert_cond_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rc)) |-> ($countones(cr[3:1]) == 1 && cr[0] == $past(so_in)));

  assert_cond_equal_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rc) && $past(a) == $past(b)) |-> cr[1]);

  assert_cond_off_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rc)) |-> cr == 4'b0000);
endmodule

bind minmax_unit minmax_unit_checker #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .a(a), .b(b), .ra_is_zero(ra_is_zero), .mode(mode),
  .rc(rc), .so_in(so_in), .result(result), .cr(cr)
);

// File: tb/minmax_unit_test.sv
module minmax_unit_test;
  localparam int XLEN = 64;
  localparam int HALF = XLEN / 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [XLEN-1:0] a = '0, b = '0;
  logic            ra_is_zero = 1'b0;
  logic [2:0]      mode = 3'b000;
  logic            rc = 1'b0, so_in = 1'b0;
  logic [XLEN-1:0] result;
  logic [3:0]      cr;

  int applied = 0;
  int miscompares = 0;

  typedef struct {
    logic [XLEN-1:0] exp_res;
    logic [3:0]      exp_cr;
    string           tag;
  } item_t;

  item_t pending[$];
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  minmax_unit #(.XLEN(XLEN)) uut (
    .clk(clk), .rst(rst), .a(a), .b(b), .ra_is_zero(ra_is_zero), .mode(mode),
    .rc(rc), .so_in(so_in), .result(result), .cr(cr)
  );

  // ordering of x against y under the width and sign rules: -1, 0, +1
  function automatic int order_of(input logic [XLEN-1:0] x, input logic [XLEN-1:0] y,
                                  input logic half, input logic sgn);
    if (half) begin
      if (sgn) begin
        if ($signed(x[HALF-1:0]) < $signed(y[HALF-1:0])) return -1;
        if ($signed(x[HALF-1:0]) > $signed(y[HALF-1:0])) return 1;
      end else begin
        if (x[HALF-1:0] < y[HALF-1:0]) return -1;
        if (x[HALF-1:0] > y[HALF-1:0]) return 1;
      end
    end else begin
      if (sgn) begin
        if ($signed(x) < $signed(y)) return -1;
        if ($signed(x) > $signed(y)) return 1;
      end else begin
        if (x < y) return -1;
        if (x > y) return 1;
      end
    end
    return 0;
  endfunction

  task automatic apply(input logic [XLEN-1:0] ta, input logic [XLEN-1:0] tb_,
                       input logic traz, input logic [2:0] tmode,
                       input logic trc, input logic tso, input string tag);
    item_t it;
    int    o;
    logic  take_a;
    o = order_of(ta, tb_, tmode[0], tmode[1]);
    take_a = tmode[2] ? (o >= 0) : (o <= 0);
    it.exp_res = take_a ? (traz ? '0 : ta) : tb_;
    it.exp_cr  = trc ? {o < 0, o > 0, o == 0, tso} : 4'b0000;
    it.tag     = tag;
    @(negedge clk);
    a = ta; b = tb_; ra_is_zero = traz; mode = tmode; rc = trc; so_in = tso;
    pending.push_back(it);
  endtask

  // monitor: each queued item is captured by the next rising edge
  always @(posedge clk) begin
    #1;
    if (pending.size() > 0) begin
      item_t it;
      it = pending.pop_front();
      applied++;
      if (result !== it.exp_res || cr !== it.exp_cr) begin
        miscompares++;
        $display("FAIL %s: result=%h cr=%b expected result=%h cr=%b",
                 it.tag, result, cr, it.exp_res, it.exp_cr);
      end
    end
  end

  initial begin
    #200000;
    miscompares++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    logic [XLEN-1:0] neg1, one, mostneg, mostpos;
    neg1 = '1; one = 1; mostneg = {1'b1, {(XLEN-1){1'b0}}}; mostpos = ~mostneg;
    // R1: outputs cleared under reset (inputs nonzero)
    a = 64'hDEAD; b = 64'hBEEF; rc = 1'b1; so_in = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    applied++;
    if (result !== '0 || cr !== 4'b0000) begin
      miscompares++;
      $display("FAIL R1: result=%h cr=%b expected result=0 cr=0000", result, cr);
    end
    @(negedge clk);
    rst = 1'b0;

    apply(64'd5, 64'd9, 0, 3'b000, 0, 0, "R2 min small");
    apply(neg1, one, 0, 3'b000, 0, 0, "R2 unsigned large");
    apply(64'd9, 64'd5, 0, 3'b000, 0, 0, "R2 min swapped");
    apply(64'd5, 64'd9, 0, 3'b100, 0, 0, "R5 max");
    apply(neg1, one, 0, 3'b100, 0, 0, "R5 max unsigned");
    apply(neg1, one, 0, 3'b010, 0, 0, "R3 signed min");
    apply(neg1, one, 0, 3'b110, 0, 0, "R3 signed max");
    apply(mostneg, mostpos, 0, 3'b010, 0, 0, "R3 extremes");
    apply(64'hAAAA_0000_0000_0003, 64'h1111_0000_0000_0002, 0, 3'b001, 0, 0, "R4 half min");
    apply(64'h0000_0000_FFFF_FFFF, 64'hFFFF_0000_0000_0001, 0, 3'b011, 0, 0, "R4 half signed min");
    apply(64'h0000_0000_FFFF_FFFF, 64'hFFFF_0000_0000_0001, 0, 3'b101, 0, 0, "R4 half unsigned max");
    apply(64'h0000_0000_FFFF_FFFF, 64'hFFFF_0000_0000_0001, 0, 3'b111, 0, 0, "R4 half signed max");
    apply(64'h1234, 64'h1234, 0, 3'b000, 0, 0, "R6 tie min");
    apply(64'h1234_5678_0000_0007, 64'h9999_0000_0000_0007, 0, 3'b001, 0, 0, "R6 half tie min");
    apply(64'h1234_5678_0000_0007, 64'h9999_0000_0000_0007, 0, 3'b101, 0, 0, "R6 half tie max");
    apply(64'd3, 64'd8, 1, 3'b000, 0, 0, "R7 zero when a chosen");
    apply(64'd3, 64'd8, 1, 3'b100, 0, 0, "R7 no effect when b chosen");
    apply(64'd7, 64'd7, 1, 3'b100, 0, 0, "R7 tie zero");
    apply(64'd3, 64'd8, 0, 3'b000, 1, 0, "R8 less in min");
    apply(64'd3, 64'd8, 0, 3'b100, 1, 0, "R8 less in max");
    apply(64'd8, 64'd3, 0, 3'b000, 1, 1, "R8 greater with so");
    apply(64'd8, 64'd8, 0, 3'b100, 1, 0, "R8 equal");
    apply(neg1, one, 0, 3'b011, 1, 1, "R8 signed half less");
    apply(64'd8, 64'd3, 0, 3'b010, 0, 1, "R9 cond off");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule